// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a two-level tree of page tables held in memory. The virtual page number is split into an upper index and a lower index. The upper index is added to a table base input to locate a first-level entry. That entry names the base of a second-level table, which the lower index then selects. The second-level entry supplies the frame number. The frame number is placed above the page offset, which passes through unchanged.

Each walk costs two memory reads, or one if the first-level entry is absent. The walker issues each read as a one-cycle request pulse on a single-port read interface. It then holds the address until an acknowledge returns the data, which takes one or more cycles. Only one walk runs at a time. If the valid bit is clear at either level, the walk ends with a fault code that names the level. The walker does not service faults and does not cache translations.

With the defaults, the virtual address is 20 bits: a 5-bit upper index, a 5-bit lower index and a 10-bit offset. The physical address is 16 bits: a 6-bit frame and the offset. Table entries are 16 bits wide. Bit 15 is the valid bit and bits 14:0 carry a 15-bit memory address or, in the low 6 bits, the frame.

Top module: `pgwalk_top`

## Requirements
- R1: After reset `req_ready` is 1, `mem_req` is 0 and `done_valid` is 0.
- R2: A start is accepted when `req_valid` and `req_ready` are both high at a clock edge. In the next cycle `mem_req` pulses for one cycle with `mem_addr` = (`tbl_base` + `req_vaddr[19:15]`) mod 2^15. `mem_addr` stays stable until `mem_ack`.
- R3: If the first-level entry has bit 15 set, the second read pulses in the cycle after its acknowledge. Its address is (entry[14:0] + `req_vaddr[14:10]`) mod 2^15, and it is held until its acknowledge.
- R4: If the second-level entry has bit 15 set, `done_paddr` = {entry[5:0], `req_vaddr[9:0]`} and `done_fault` = 0.
- R5: A first-level entry with bit 15 clear ends the walk with `done_fault` = 1 and `done_paddr` = 0, and no second read is issued.
- R6: A second-level entry with bit 15 clear ends the walk with `done_fault` = 2 and `done_paddr` = 0.
- R7: `done_valid` is high for exactly one cycle. With acknowledge latencies La and Lb, counted in cycles from the request pulse, it rises 3+La+Lb cycles after the accepting edge on success or on a second-level fault. It rises 2+La cycles after that edge on a first-level fault. `req_ready` returns in the cycle after `done_valid`.
- R8: While a walk is in progress `req_ready` is 0 and `req_valid` is ignored. A `mem_ack` outside the two waiting phases has no effect.
- R9: A walk that reaches the second level makes exactly two memory reads, and a first-level fault makes exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a translation |
| req_ready | output | 1 | Walker is idle and can accept a start |
| req_vaddr | input | 20 | Virtual address to translate |
| tbl_base | input | 15 | Memory address of the first-level table |
| mem_req | output | 1 | One-cycle read request pulse |
| mem_addr | output | 15 | Read address, held until acknowledge |
| mem_ack | input | 1 | Read data is valid |
| mem_rdata | input | 16 | Table entry read from memory |
| done_valid | output | 1 | Result is valid for this cycle |
| done_paddr | output | 16 | Translated physical address |
| done_fault | output | 2 | 0 none, 1 first-level absent, 2 second-level absent |

## Verification
Every result has a fixed due cycle, counted from the accepting edge. The first read pulse is due one cycle after that edge. The second read is due one cycle after the first acknowledge. The result is due 3+La+Lb cycles after the edge, or 2+La cycles for a first-level fault.

The bench's behavioural model advances on each rising edge from the same port values the design sees. The bench compares all outputs at the following falling edge, so each expectation is checked in exactly the cycle it is due. Each walk also counts falling edges until `done_valid` and compares that count with the latency formula. Acknowledge latencies are set per read to show that the timing follows the memory and not a fixed delay.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD1  = 3'd1,
    ST_WT1  = 3'd2,
    ST_RD2  = 3'd3,
    ST_WT2  = 3'd4,
    ST_DONE = 3'd5
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_LVL1 = 2'd1,
    FLT_LVL2 = 2'd2
  } walk_flt_e;

endpackage

// File: rtl/pgwalk_seq.sv
module pgwalk_seq
  import pgwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     ack_i,
  input  logic     ent_ok_i,
  output walk_st_e st_o,
  output logic     accept_o,
  output logic     take1_o,
  output logic     take2_o
);

  walk_st_e st_q, st_d;

  // events: named so the datapath and checker can observe them
  assign accept_o = (st_q == ST_IDLE) && start_i;
  assign take1_o  = (st_q == ST_WT1) && ack_i;
  assign take2_o  = (st_q == ST_WT2) && ack_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) st_d = ST_RD1;
      ST_RD1:  st_d = ST_WT1;
      ST_WT1:  if (take1_o) st_d = ent_ok_i ? ST_RD2 : ST_DONE;
      ST_RD2:  st_d = ST_WT2;
      ST_WT2:  if (take2_o) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

endmodule

// File: rtl/pgwalk_path.sv
module pgwalk_path
  import pgwalk_pkg::*;
#(
  parameter int VA_W  = 20,
  parameter int OFF_W = 10,
  parameter int IX1_W = 5,
  parameter int IX2_W = 5,
  parameter int FRM_W = 6,
  parameter int MA_W  = 15,
  parameter int ENT_W = 16,
  localparam int PA_W = FRM_W + OFF_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  walk_st_e         st_i,
  input  logic             accept_i,
  input  logic             take1_i,
  input  logic             take2_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [MA_W-1:0]  base_i,
  input  logic [ENT_W-1:0] rdata_i,
  output logic             ent_ok_o,
  output logic [MA_W-1:0]  maddr_o,
  output logic [PA_W-1:0]  paddr_o,
  output walk_flt_e        fault_o
);

  function automatic logic [IX1_W-1:0] pick_ix1(input logic [VA_W-1:0] va);
    return va[VA_W-1 -: IX1_W];
  endfunction

  function automatic logic [IX2_W-1:0] pick_ix2(input logic [VA_W-1:0] va);
    return va[OFF_W +: IX2_W];
  endfunction

  function automatic logic [MA_W-1:0] slot_addr(input logic [MA_W-1:0] base,
                                                input logic [MA_W-1:0] ix);
    return base + ix;
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [ENT_W-1:0] ent,
                                              input logic [VA_W-1:0]  va);
    return {ent[FRM_W-1:0], va[OFF_W-1:0]};
  endfunction

  logic [VA_W-1:0] va_q;
  logic [MA_W-1:0] base_q;
  logic [MA_W-1:0] l2b_q;
  logic [PA_W-1:0] pa_q;
  walk_flt_e       flt_q;
  logic            lvl2;

  assign ent_ok_o = rdata_i[ENT_W-1];
  assign lvl2     = (st_i == ST_RD2) || (st_i == ST_WT2);
  assign maddr_o  = lvl2 ? slot_addr(l2b_q, MA_W'(pick_ix2(va_q)))
                         : slot_addr(base_q, MA_W'(pick_ix1(va_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      l2b_q  <= '0;
      pa_q   <= '0;
      flt_q  <= FLT_NONE;
    end else begin
      if (accept_i) begin
        va_q   <= vaddr_i;
        base_q <= base_i;
        pa_q   <= '0;
        flt_q  <= FLT_NONE;
      end
      if (take1_i) begin
        if (ent_ok_o) l2b_q <= rdata_i[MA_W-1:0];
        else          flt_q <= FLT_LVL1;
      end
      if (take2_i) begin
        if (ent_ok_o) pa_q  <= join_pa(rdata_i, va_q);
        else          flt_q <= FLT_LVL2;
      end
    end
  end

  assign paddr_o = pa_q;
  assign fault_o = flt_q;

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int VA_W  = 20,
  parameter int OFF_W = 10,
  parameter int IX1_W = 5,
  parameter int IX2_W = 5,
  parameter int FRM_W = 6,
  parameter int MA_W  = 15,
  parameter int ENT_W = 16,
  localparam int PA_W = FRM_W + OFF_W
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [MA_W-1:0]  tbl_base,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [ENT_W-1:0] mem_rdata,
  output logic             done_valid,
  output logic [PA_W-1:0]  done_paddr,
  output logic [1:0]       done_fault
);

  walk_st_e  st;
  walk_flt_e flt;
  logic      ev_accept, ev_take1, ev_take2, ent_ok;
  logic      walk_wait;

  pgwalk_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (req_valid),
    .ack_i    (mem_ack),
    .ent_ok_i (ent_ok),
    .st_o     (st),
    .accept_o (ev_accept),
    .take1_o  (ev_take1),
    .take2_o  (ev_take2)
  );

  pgwalk_path #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IX1_W(IX1_W), .IX2_W(IX2_W),
    .FRM_W(FRM_W), .MA_W(MA_W), .ENT_W(ENT_W)
  ) u_path (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_i     (st),
    .accept_i (ev_accept),
    .take1_i  (ev_take1),
    .take2_i  (ev_take2),
    .vaddr_i  (req_vaddr),
    .base_i   (tbl_base),
    .rdata_i  (mem_rdata),
    .ent_ok_o (ent_ok),
    .maddr_o  (mem_addr),
    .paddr_o  (done_paddr),
    .fault_o  (flt)
  );

  assign req_ready  = (st == ST_IDLE);
  assign mem_req    = (st == ST_RD1) || (st == ST_RD2);
  assign walk_wait  = (st == ST_WT1) || (st == ST_WT2);
  assign done_valid = (st == ST_DONE);
  assign done_fault = flt;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int MA_W = 15
)(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req,
  input logic [MA_W-1:0] mem_addr,
  input logic            mem_ack,
  input logic            walk_wait,
  input logic            done_valid,
  input logic [1:0]      done_fault
);

  // R2
  start_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> mem_req);

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req && walk_wait);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_wait && !mem_ack |=> $stable(mem_addr));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && req_ready);

  // R8
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !walk_wait && !done_valid);

  // R6
  fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> done_fault != 2'd3);

endmodule

bind pgwalk_top pgwalk_chk #(.MA_W(MA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .walk_wait  (walk_wait),
  .done_valid (done_valid),
  .done_fault (done_fault)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vaddr = '0;
  logic [14:0] tbl_base = '0;
  logic        mem_req;
  logic [14:0] mem_addr;
  logic        mem_ack;
  logic [15:0] mem_rdata;
  logic        done_valid;
  logic [15:0] done_paddr;
  logic [1:0]  done_fault;

  logic        resp_ack = 1'b0;
  logic [15:0] resp_data = '0;
  logic        stray_ack = 1'b0;

  assign mem_ack   = resp_ack | stray_ack;
  assign mem_rdata = stray_ack ? 16'hFFFF : resp_data;

  always #4 clk = ~clk;   // 125 MHz

  pgwalk_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .tbl_base(tbl_base), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done_valid(done_valid), .done_paddr(done_paddr), .done_fault(done_fault)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // table memory and responder
  logic [15:0] tbl [int];
  int lat_a = 1, lat_b = 1, reads = 0, cnt = 0;
  int addr_log [2];

  function automatic logic [15:0] rd(input int a);
    return tbl.exists(a) ? tbl[a] : 16'h0000;
  endfunction

  int pend_addr = 0;
  always @(negedge clk) begin
    resp_ack = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        resp_ack  = 1'b1;
        resp_data = rd(pend_addr);
      end
    end
    if (rst_n && mem_req) begin
      pend_addr = int'(mem_addr);
      if (reads < 2) addr_log[reads] = pend_addr;
      cnt = (reads == 0) ? lat_a : lat_b;
      reads++;
    end
  end

  // behavioural reference model, advanced at each rising edge
  int ph = 0, m_va = 0, m_base = 0, m_l2b = 0, m_pa = 0, m_flt = 0;
  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else if (ph == 0) begin
      if (req_valid) begin
        m_va = int'(req_vaddr); m_base = int'(tbl_base); m_pa = 0; m_flt = 0; ph = 1;
      end
    end else if (ph == 1 || ph == 3) ph++;
    else if (ph == 2) begin
      if (mem_ack) begin
        if (mem_rdata[15]) begin m_l2b = int'(mem_rdata) % 32768; ph = 3; end
        else begin m_flt = 1; ph = 5; end
      end
    end else if (ph == 4) begin
      if (mem_ack) begin
        if (mem_rdata[15]) m_pa = (int'(mem_rdata) % 64) * 1024 + m_va % 1024;
        else m_flt = 2;
        ph = 5;
      end
    end else ph = 0;
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(req_ready == (ph == 0), "R8 req_ready", req_ready, ph == 0);
      chk(mem_req == (ph == 1 || ph == 3), "R2 mem_req", mem_req, ph == 1 || ph == 3);
      chk(done_valid == (ph == 5), "R7 done_valid", done_valid, ph == 5);
      if (ph == 1 || ph == 2)
        chk(int'(mem_addr) == (m_base + m_va / 32768) % 32768, "R2 mem_addr",
            mem_addr, (m_base + m_va / 32768) % 32768);
      if (ph == 3 || ph == 4)
        chk(int'(mem_addr) == (m_l2b + (m_va / 1024) % 32) % 32768, "R3 mem_addr",
            mem_addr, (m_l2b + (m_va / 1024) % 32) % 32768);
      if (ph == 5) begin
        chk(int'(done_fault) == m_flt, "R4 done_fault", done_fault, m_flt);
        chk(int'(done_paddr) == m_pa, "R4 done_paddr", done_paddr, m_pa);
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic walk(input int p1, input int p2, input int off, input int base,
                      input int la, input int lb, input bit hold,
                      input int e_flt, input int e_pa, input int e_reads,
                      input int e_a1, input int e_a2);
    int n;
    int e_cyc;
    e_cyc = (e_flt == 1) ? 2 + la : 3 + la + lb;
    @(negedge clk);
    lat_a = la; lat_b = lb; reads = 0;
    req_vaddr = 20'(p1 * 32768 + p2 * 1024 + off);
    tbl_base  = 15'(base);
    req_valid = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (!hold) req_valid = 1'b0;
    end while (!done_valid && n < 100);
    req_valid = 1'b0;
    chk(n == e_cyc, "R7 done latency", n, e_cyc);
    chk(int'(done_fault) == e_flt, (e_flt == 1) ? "R5 fault" : (e_flt == 2) ? "R6 fault" : "R4 fault",
        done_fault, e_flt);
    chk(int'(done_paddr) == e_pa, "R4 paddr", done_paddr, e_pa);
    chk(addr_log[0] == e_a1, "R2 first address", addr_log[0], e_a1);
    if (e_reads == 2) chk(addr_log[1] == e_a2, "R3 second address", addr_log[1], e_a2);
    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready after done", req_ready, 1);
    chk(reads == e_reads, "R9 read count", reads, e_reads);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && mem_req == 1'b0 && done_valid == 1'b0, "R1 reset state",
        {req_ready, mem_req, done_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && mem_req == 1'b0 && done_valid == 1'b0, "R1 after release",
        {req_ready, mem_req, done_valid}, 3'b100);

    // success, fastest memory
    tbl[16'h0103] = 16'h8400;
    tbl[16'h0407] = 16'h802A;
    walk(3, 7, 'h155, 'h0100, 1, 1, 0, 0, 'h2A * 1024 + 'h155, 2, 'h0103, 'h0407);

    // success, slower memory, extreme indices
    tbl[16'h201F] = 16'h9234;
    tbl[16'h1234] = 16'h803F;
    walk(31, 0, 'h3FF, 'h2000, 3, 2, 0, 0, 'h3F * 1024 + 'h3FF, 2, 'h201F, 'h1234);

    // first-level absent: valid clear although payload non-zero
    tbl[16'h0509] = 16'h0ABC;
    walk(9, 4, 'h011, 'h0500, 2, 1, 0, 1, 0, 1, 'h0509, 0);

    // second-level absent
    tbl[16'h0602] = 16'h8700;
    tbl[16'h070C] = 16'h0015;
    walk(2, 12, 'h2A0, 'h0600, 1, 4, 0, 2, 0, 2, 'h0602, 'h070C);

    // address wrap at both levels, start held high during the walk (R8)
    tbl[3] = 16'hFFFD;
    tbl[6] = 16'h8011;
    walk(5, 9, 'h0C3, 'h7FFE, 2, 2, 1, 0, 'h11 * 1024 + 'hC3, 2, 3, 6);

    // stray acknowledges while idle are ignored (R8)
    @(negedge clk);
    stray_ack = 1'b1;
    repeat (2) @(negedge clk);
    stray_ack = 1'b0;
    chk(req_ready == 1'b1 && mem_req == 1'b0 && done_valid == 1'b0, "R8 stray ack idle",
        {req_ready, mem_req, done_valid}, 3'b100);

    // a normal walk right after still resolves correctly
    walk(3, 7, 'h001, 'h0100, 1, 2, 0, 0, 'h2A * 1024 + 'h001, 2, 'h0103, 'h0407);

    summary();
    $finish;
  end

endmodule